// File: doc/BRIEF.md
# Selectable UART baud clock generator

This block derives the serial timing strobes for a UART from the system clock. The clock arrives already qualified: a one-cycle machine-clock enable pulse marks each cycle that counts. A three-bit clock-select code and a mode input choose the rate. In synchronous mode the qualified rate is divided by a power of two. In asynchronous mode the block first produces an oversampling strobe at eight times the bit rate and then a bit strobe on every eighth of those strobes. The oversampling strobe comes from a fixed prescaler of 13 or 2, picked by the top select bit, followed by a power-of-two divider.

The surrounding shift logic reads `bit_tick` and `ovs_tick` as single-cycle strobes. A change of mode or select code, a low block enable, or a reserved code clears every internal counter. Counting then resumes from zero.

Top module: `uart_baud_gen`

## Requirements
- R1: In synchronous mode (`async_mode`=0), select codes 0 to 5 give one `bit_tick` per 2^code qualified cycles. With code 0 a tick follows every qualified cycle.
- R2: In asynchronous mode, select codes 0 to 3 give one `bit_tick` per 8×13×2^(code+1) qualified cycles.
- R3: In asynchronous mode, select codes 4 and 5 give one `bit_tick` per 8×2×2^(code−3) qualified cycles.
- R4: In asynchronous mode, `ovs_tick` fires once per one eighth of the bit period, and every `bit_tick` coincides with an `ovs_tick`. In synchronous mode `ovs_tick` stays low.
- R5: Select codes 6 and 7 are reserved. While either is applied, no tick of either kind occurs and the counters are held cleared.
- R6: A cycle in which the mode or select code differs from the previous cycle clears all counters and produces no tick. The first tick at the new setting follows one full period of qualified cycles later.
- R7: While `en` is low, no tick occurs and the counters are held cleared.
- R8: Ticks are registered. A tick is high in the cycle after the qualified cycle (`en` and `mclk_en` high) that completes a period. It is never high after a cycle without `mclk_en`. Both ticks are low during reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Block enable |
| mclk_en | input | 1 | One-cycle machine-clock qualifier |
| async_mode | input | 1 | 1 = asynchronous (oversampled), 0 = synchronous |
| sel | input | 3 | Clock-select code |
| bit_tick | output | 1 | One-cycle strobe at the serial bit rate |
| ovs_tick | output | 1 | One-cycle strobe at eight times the bit rate (asynchronous mode only) |

## Verification
A stage counter left in a wrong state shows at the ports as a tick in the wrong cycle. It may also show as a missing tick within one period of the selected rate, which is at most 1664 qualified cycles. A stale configuration copy shows as a tick in the cycle right after a mode or code change, or as a first period that is too short. The bench sweeps every mode and code with dense and irregular qualifiers and compares both strobes on every cycle against an arithmetic count.

// File: rtl/uart_baud_pkg.sv
package uart_baud_pkg;

  // Rate configuration as seen by the generator
  typedef struct packed {
    logic       async_m;
    logic [2:0] code;
  } baud_cfg_t;

  localparam int unsigned NUM_CODES = 6;

endpackage

// File: rtl/uart_baud_stage.sv
// One modulo stage of the divider cascade; wraps after lim+1 increments.
module uart_baud_stage #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  input  logic [W-1:0] lim,
  output logic         wrap
);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;

  always_comb begin
    wrap = inc && (cnt_q == lim);
    if (clr) begin
      cnt_d = '0;
    end else if (wrap) begin
      cnt_d = '0;
    end else if (inc) begin
      cnt_d = cnt_q + 1'b1;
    end else begin
      cnt_d = cnt_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/uart_baud_cfg.sv
// Decodes mode and select code into per-stage limits.
module uart_baud_cfg
  import uart_baud_pkg::*;
#(
  parameter int unsigned PRE_HI = 13,
  parameter int unsigned PRE_LO = 2,
  parameter int unsigned OVS    = 8,
  parameter int unsigned A_W    = 4,
  parameter int unsigned B_W    = 5,
  parameter int unsigned C_W    = 3
) (
  input  baud_cfg_t      cfg,
  output logic           valid,
  output logic [A_W-1:0] lim_a,
  output logic [B_W-1:0] lim_b,
  output logic [C_W-1:0] lim_c
);

  logic [2:0] pow_exp;

  always_comb begin
    valid = (32'(cfg.code) < NUM_CODES);
    if (cfg.async_m) begin
      lim_a   = cfg.code[2] ? A_W'(PRE_LO - 1) : A_W'(PRE_HI - 1);
      pow_exp = cfg.code[2] ? (3'({1'b0, cfg.code[0]}) + 3'd1)
                            : (3'(cfg.code[1:0]) + 3'd1);
      lim_c   = C_W'(OVS - 1);
    end else begin
      lim_a   = '0;
      pow_exp = cfg.code;
      lim_c   = '0;
    end
    lim_b = B_W'((32'd1 << pow_exp) - 32'd1);
  end

endmodule

// File: rtl/uart_baud_gen.sv
module uart_baud_gen
  import uart_baud_pkg::*;
#(
  parameter int unsigned PRE_HI       = 13,
  parameter int unsigned PRE_LO       = 2,
  parameter int unsigned OVS          = 8,
  parameter int unsigned SYNC_MAX_DIV = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       mclk_en,
  input  logic       async_mode,
  input  logic [2:0] sel,
  output logic       bit_tick,
  output logic       ovs_tick
);

  localparam int unsigned PRE_MAX = (PRE_HI > PRE_LO) ? PRE_HI : PRE_LO;
  localparam int unsigned A_W     = (PRE_MAX > 2) ? $clog2(PRE_MAX) : 1;
  localparam int unsigned B_W     = (SYNC_MAX_DIV > 2) ? $clog2(SYNC_MAX_DIV) : 1;
  localparam int unsigned C_W     = (OVS > 2) ? $clog2(OVS) : 1;

  baud_cfg_t      cfg_now;
  baud_cfg_t      cfg_q;
  logic           cfg_chg;
  logic           cfg_ok;
  logic           clr;
  logic [A_W-1:0] lim_a;
  logic [B_W-1:0] lim_b;
  logic [C_W-1:0] lim_c;
  logic           inc_a;
  logic           wrap_a;
  logic           wrap_b;
  logic           wrap_c;
  logic           bit_d;
  logic           ovs_d;
  logic           bit_q;
  logic           ovs_q;

  always_comb begin
    cfg_now.async_m = async_mode;
    cfg_now.code    = sel;
    cfg_chg         = (cfg_now != cfg_q);
    clr             = cfg_chg || !en || !cfg_ok;
    inc_a           = mclk_en && !clr;
    bit_d           = wrap_c;
    ovs_d           = wrap_b && async_mode;
  end

  uart_baud_cfg #(
    .PRE_HI(PRE_HI), .PRE_LO(PRE_LO), .OVS(OVS),
    .A_W(A_W), .B_W(B_W), .C_W(C_W)
  ) i_cfg (
    .cfg   (cfg_now),
    .valid (cfg_ok),
    .lim_a (lim_a),
    .lim_b (lim_b),
    .lim_c (lim_c)
  );

  // Prescaler (13 or 2 in asynchronous mode, pass-through otherwise)
  uart_baud_stage #(.W(A_W)) i_pre (
    .clk(clk), .rst_n(rst_n), .clr(clr), .inc(inc_a), .lim(lim_a), .wrap(wrap_a)
  );

  // Power-of-two divider; its wrap is the oversampling strobe
  uart_baud_stage #(.W(B_W)) i_pow (
    .clk(clk), .rst_n(rst_n), .clr(clr), .inc(wrap_a), .lim(lim_b), .wrap(wrap_b)
  );

  // Oversample-to-bit divider (eight in asynchronous mode, pass-through otherwise)
  uart_baud_stage #(.W(C_W)) i_ovs (
    .clk(clk), .rst_n(rst_n), .clr(clr), .inc(wrap_b), .lim(lim_c), .wrap(wrap_c)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
      bit_q <= 1'b0;
      ovs_q <= 1'b0;
    end else begin
      cfg_q <= cfg_now;
      bit_q <= bit_d;
      ovs_q <= ovs_d;
    end
  end

  assign bit_tick = bit_q;
  assign ovs_tick = ovs_q;

endmodule

// File: rtl/uart_baud_gen_chk.sv
module uart_baud_gen_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       en,
  input logic       mclk_en,
  input logic       async_mode,
  input logic [2:0] sel,
  input logic       bit_tick,
  input logic       ovs_tick
);

  a_r8_bit_after_qual: assert property (@(posedge clk) disable iff (!rst_n)
    bit_tick |-> $past(mclk_en && en));

  a_r8_ovs_after_qual: assert property (@(posedge clk) disable iff (!rst_n)
    ovs_tick |-> $past(mclk_en && en));

  a_r5_reserved_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (sel[2:1] == 2'b11) |=> (!bit_tick && !ovs_tick));

  a_r7_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!bit_tick && !ovs_tick));

  a_r4_no_ovs_sync: assert property (@(posedge clk) disable iff (!rst_n)
    !async_mode |=> !ovs_tick);

  a_r4_bit_with_ovs: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_tick && $past(async_mode)) |-> ovs_tick);

  a_r6_change_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    ((sel != $past(sel)) || (async_mode != $past(async_mode))) |=> (!bit_tick && !ovs_tick));

endmodule

bind uart_baud_gen uart_baud_gen_chk i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .en         (en),
  .mclk_en    (mclk_en),
  .async_mode (async_mode),
  .sel        (sel),
  .bit_tick   (bit_tick),
  .ovs_tick   (ovs_tick)
);

// File: tb/test_uart_baud_gen.sv
module test_uart_baud_gen;

  logic       clk;
  logic       rst_n;
  logic       en;
  logic       mclk_en;
  logic       async_mode;
  logic [2:0] sel;
  logic       bit_tick;
  logic       ovs_tick;

  int checks;
  int errors;
  int cnt;
  logic       p_async;
  logic [2:0] p_sel;
  logic [15:0] lfsr;

  uart_baud_gen i_uart_baud_gen (
    .clk(clk), .rst_n(rst_n), .en(en), .mclk_en(mclk_en),
    .async_mode(async_mode), .sel(sel), .bit_tick(bit_tick), .ovs_tick(ovs_tick)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic int ovs_period(input logic a, input logic [2:0] s);
    int pre;
    int m;
    pre = (s >= 3'd4) ? 2 : 13;
    m   = (s >= 3'd4) ? (2 << (s - 3'd4)) : (2 << s);
    return a ? pre * m : (1 << s);
  endfunction

  function automatic int bit_period(input logic a, input logic [2:0] s);
    return a ? 8 * ovs_period(a, s) : (1 << s);
  endfunction

  task automatic check(input string tag, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: %s=%0b expected %0b", tag, what, act, exp);
    end
  endtask

  // Drive one cycle at a negedge, model it, check the registered result one cycle later
  task automatic step(input logic e, input logic m, input logic a, input logic [2:0] s);
    logic  chg;
    logic  ok;
    logic  eb;
    logic  eo;
    string tag;
    en = e; mclk_en = m; async_mode = a; sel = s;
    chg = (a != p_async) || (s != p_sel);
    ok  = (s <= 3'd5);
    eb = 1'b0; eo = 1'b0;
    if (chg || !e || !ok) begin
      cnt = 0;
    end else if (m) begin
      cnt++;
      eb = (cnt % bit_period(a, s)) == 0;
      eo = a && ((cnt % ovs_period(a, s)) == 0);
    end
    if (!e)              tag = "R7";
    else if (chg)        tag = "R6";
    else if (!ok)        tag = "R5";
    else if (!m)         tag = "R8";
    else if (!a)         tag = "R1";
    else if (s < 3'd4)   tag = "R2";
    else                 tag = "R3";
    p_async = a; p_sel = s;
    @(posedge clk);
    @(negedge clk);
    check(tag, "bit_tick", bit_tick, eb);
    check(a ? "R4" : "R4 sync", "ovs_tick", ovs_tick, eo);
  endtask

  function automatic logic rnd();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    return lfsr[0];
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish, actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    checks = 0; errors = 0; cnt = 0;
    lfsr = 16'hACE1;
    rst_n = 1'b0; en = 1'b0; mclk_en = 1'b0; async_mode = 1'b0; sel = 3'd0;
    p_async = 1'b0; p_sel = 3'd0;
    repeat (3) @(negedge clk);
    // R8: reset state
    check("R8", "bit_tick in reset", bit_tick, 1'b0);
    check("R8", "ovs_tick in reset", ovs_tick, 1'b0);
    rst_n = 1'b1;

    // Sweep every mode and code: dense qualifier, then irregular qualifier
    for (int a = 0; a < 2; a++) begin
      for (int s = 0; s < 8; s++) begin
        int n;
        n = (s <= 5) ? bit_period(a[0], s[2:0]) : 10;
        for (int k = 0; k < 2 * n + 3; k++) step(1'b1, 1'b1, a[0], s[2:0]);
        for (int k = 0; k < 2 * n + 3; k++) step(1'b1, rnd(), a[0], s[2:0]);
      end
    end

    // R7: enable dropped mid-period restarts counting
    for (int k = 0; k < 20; k++) step(1'b1, 1'b1, 1'b1, 3'd4);
    for (int k = 0; k < 3; k++)  step(1'b0, 1'b1, 1'b1, 3'd4);
    for (int k = 0; k < 70; k++) step(1'b1, 1'b1, 1'b1, 3'd4);

    // R6: mode flip mid-period with the same code, then back
    for (int k = 0; k < 5; k++)   step(1'b1, 1'b1, 1'b0, 3'd5);
    for (int k = 0; k < 200; k++) step(1'b1, 1'b1, 1'b1, 3'd5);
    for (int k = 0; k < 70; k++)  step(1'b1, 1'b1, 1'b0, 3'd5);

    // R1: code 0 with qualifier held high ticks every cycle
    for (int k = 0; k < 10; k++) step(1'b1, 1'b1, 1'b0, 3'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule